// File: doc/BRIEF.md
# Transmit Abort Frame Terminator

This block sits in the transmit path of a MAC, between the source of frame data and the line interface. Frame data arrives one nibble per cycle, low nibble of each byte first. The block registers each nibble onto the line, keeps a running CRC-32 over the bytes it has sent, and counts the bits sent so far in the current frame. A frame that ends normally is followed at once by its correct 32-bit frame check sequence.

When an abort request arrives during a frame, the block ends the frame in one of two ways. If fewer than 512 bits have been sent, it drops the line at once and leaves a runt. If 512 or more bits have been sent, it finishes the byte in progress with data from the source. It then sends the bitwise inverse of the correct FCS, so that any receiver sees a checksum error. A one-cycle completion pulse and a runt flag report which path was taken.

Top module: `tx_abort_term`

## Requirements
- R1: While reset is held and after it is released with no input activity, `tx_en`, `abort_done` and `abort_runt` are 0.
- R2: Each nibble accepted with `in_valid` appears on `tx_nib` with `tx_en` high on the next cycle, in arrival order. The first byte of a frame is formed from the first nibble (bits 3:0) and the second nibble (bits 7:4).
- R3: A nibble accepted with `in_last` high is followed with no gap by eight FCS nibbles. The FCS is the complement of the reflected CRC-32 (generator 0x04C11DB7, preset all ones), computed bit by bit from bit 0 of each frame byte. It is sent least significant nibble first. For the bytes "123456789" the FCS is 0xCBF43926.
- R4: An abort while fewer than 512 bits have been sent makes `tx_en` low on the next cycle. No FCS follows, and the nibble offered in the abort cycle is not sent. `abort_done` pulses in that same next cycle, with `abort_runt` at 1.
- R5: An abort when at least 512 bits and a whole number of bytes have been sent drops the nibble offered in that cycle. On the next cycle it starts eight nibbles that are the bitwise inverse of the correct FCS of the bytes already sent.
- R6: An abort when at least 512 bits and an odd number of nibbles have been sent first sends the next nibble from the source. That nibble is taken in the abort cycle if `in_valid` is high, otherwise at the next cycle with `in_valid` high. The inverted FCS of the bytes completed so far follows it with no gap.
- R7: After an inverted FCS, `abort_done` is high for exactly one cycle, together with its last nibble, and `abort_runt` is 0. A frame that ends normally produces no `abort_done`.
- R8: An abort when no nibble has been sent since the last frame ended, or since reset, has no effect.
- R9: While the eight FCS nibbles are being sent, `in_valid`, `in_nib`, `in_last` and `abort_req` are ignored.
- R10: The threshold is exact. An abort after 127 nibbles (508 bits) gives a runt; an abort after 128 nibbles (512 bits) gives the inverted FCS.
- R11: After any termination, the next accepted nibble starts a new frame with the CRC and the bit count reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame nibble is offered this cycle |
| in_nib | input | 4 | Offered nibble |
| in_last | input | 1 | Offered nibble is the last of the frame |
| abort_req | input | 1 | Request to end the current frame early |
| tx_en | output | 1 | Line nibble is valid |
| tx_nib | output | 4 | Nibble to the line interface |
| abort_done | output | 1 | One-cycle pulse when an aborted frame has ended |
| abort_runt | output | 1 | 1 if the last aborted frame was cut as a runt |

## Verification
The hardest case to reach is an abort that lands after the threshold but in the middle of a byte, while the source is stalled. The block must then hold the abort and wait for the completing nibble before it starts the inverted FCS. The bench reaches it by counting out an odd number of nibbles above 128, then raising the abort with `in_valid` low and offering the completing nibble a cycle later. The 127/128 nibble edge and aborts sent during an FCS are driven directly. Random frames mix abort positions on both sides of the threshold and on both nibble phases.

// File: rtl/tx_abort_pkg.sv
package tx_abort_pkg;

  // Control phases of the terminator
  typedef enum logic [1:0] {
    ST_PASS = 2'd0,   // forwarding frame nibbles (or idle)
    ST_FILL = 2'd1,   // abort accepted, waiting for the nibble that completes the byte
    ST_FCS  = 2'd2    // sending the check sequence, true or inverted
  } term_state_e;

endpackage

// File: rtl/tx_fcs_crc.sv
module tx_fcs_crc #(
  parameter int                 CRC_W     = 32,
  parameter logic [CRC_W-1:0]   POLY_REFL = 32'hEDB88320,
  parameter int                 NIB_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [NIB_W-1:0] nib,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;

  // Reflected LFSR stepped once per data bit, bit 0 of the nibble first
  always_comb begin
    crc_d = crc_q;
    for (int b = 0; b < NIB_W; b++) begin
      if (crc_d[0] ^ nib[b]) crc_d = (crc_d >> 1) ^ POLY_REFL;
      else                   crc_d = crc_d >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '1;
    else if (en)    crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R11: the register is never restarted in a cycle that also feeds it data
  a_r11_clr_not_with_update: assert property (@(posedge clk) disable iff (rst)
    !(clr && en));

endmodule

// File: rtl/tx_bit_meter.sv
module tx_bit_meter #(
  parameter int MIN_BITS = 512,
  parameter int NIB_W    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic any_sent,
  output logic long_enough,
  output logic odd_phase
);

  localparam int BW = $clog2(MIN_BITS + NIB_W) + 1;

  logic [BW-1:0] bits_q;
  logic          phase_q;

  // Bit count saturates at the threshold; only the comparison matters past it
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bits_q  <= '0;
      phase_q <= 1'b0;
    end else if (en) begin
      phase_q <= ~phase_q;
      if (bits_q < BW'(MIN_BITS)) bits_q <= bits_q + BW'(NIB_W);
    end
  end

  assign any_sent    = (bits_q != '0);
  assign long_enough = (bits_q >= BW'(MIN_BITS));
  assign odd_phase   = phase_q;

  // R10: the counter never runs past the threshold value
  a_r10_count_capped: assert property (@(posedge clk) disable iff (rst)
    bits_q <= BW'(MIN_BITS));

  // R11: a restart leaves the frame empty on the next cycle
  a_r11_restart_empty: assert property (@(posedge clk) disable iff (rst)
    clr |=> !any_sent && !odd_phase);

endmodule

// File: rtl/tx_abort_term.sv
module tx_abort_term #(
  parameter int               MIN_BITS      = 512,
  parameter int               NIB_W         = 4,
  parameter int               CRC_W         = 32,
  parameter logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_nib,
  input  logic             in_last,
  input  logic             abort_req,
  output logic             tx_en,
  output logic [NIB_W-1:0] tx_nib,
  output logic             abort_done,
  output logic             abort_runt
);
  import tx_abort_pkg::*;

  localparam int FCS_NIBS = CRC_W / NIB_W;
  localparam int IDX_W    = $clog2(FCS_NIBS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_NIBS - 1);

  term_state_e      st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             inv_q, inv_d;
  logic             en_q, en_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic             done_q, done_d;
  logic             runt_q, runt_d;

  logic             take;     // a source nibble is accepted this cycle
  logic             wipe;     // frame over: restart CRC and bit count
  logic [CRC_W-1:0] crc;
  logic             any_sent, long_enough, odd_phase;
  logic [IDX_W-1:0] sel_idx;
  logic [NIB_W-1:0] crc_nib;

  tx_fcs_crc #(
    .CRC_W     (CRC_W),
    .POLY_REFL (CRC_POLY_REFL),
    .NIB_W     (NIB_W)
  ) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (wipe),
    .en  (take),
    .nib (in_nib),
    .crc (crc)
  );

  tx_bit_meter #(
    .MIN_BITS (MIN_BITS),
    .NIB_W    (NIB_W)
  ) u_meter (
    .clk         (clk),
    .rst         (rst),
    .clr         (wipe),
    .en          (take),
    .any_sent    (any_sent),
    .long_enough (long_enough),
    .odd_phase   (odd_phase)
  );

  // Raw CRC nibble; the true FCS is its complement, the poisoned one is raw
  assign sel_idx = (st_q == ST_FCS) ? idx_q : '0;
  assign crc_nib = crc[sel_idx * NIB_W +: NIB_W];

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    inv_d  = inv_q;
    en_d   = 1'b0;
    nib_d  = nib_q;
    done_d = 1'b0;
    runt_d = runt_q;
    take   = 1'b0;
    wipe   = 1'b0;
    unique case (st_q)
      ST_PASS: begin
        if (abort_req && any_sent) begin
          if (!long_enough) begin
            // short frame: cut now
            wipe   = 1'b1;
            done_d = 1'b1;
            runt_d = 1'b1;
          end else if (odd_phase) begin
            // finish the byte in progress before the poisoned FCS
            inv_d = 1'b1;
            if (in_valid) begin
              take  = 1'b1;
              en_d  = 1'b1;
              nib_d = in_nib;
              idx_d = '0;
              st_d  = ST_FCS;
            end else begin
              st_d  = ST_FILL;
            end
          end else begin
            // on a byte boundary: first poisoned nibble goes out now
            inv_d = 1'b1;
            en_d  = 1'b1;
            nib_d = crc_nib;
            idx_d = IDX_W'(1);
            st_d  = ST_FCS;
          end
        end else if (in_valid) begin
          take  = 1'b1;
          en_d  = 1'b1;
          nib_d = in_nib;
          if (in_last) begin
            inv_d = 1'b0;
            idx_d = '0;
            st_d  = ST_FCS;
          end
        end
      end
      ST_FILL: begin
        if (in_valid) begin
          take  = 1'b1;
          en_d  = 1'b1;
          nib_d = in_nib;
          idx_d = '0;
          st_d  = ST_FCS;
        end
      end
      ST_FCS: begin
        en_d  = 1'b1;
        nib_d = inv_q ? crc_nib : ~crc_nib;
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == IDX_LAST) begin
          st_d = ST_PASS;
          wipe = 1'b1;
          if (inv_q) begin
            done_d = 1'b1;
            runt_d = 1'b0;
          end
        end
      end
      default: st_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_PASS;
      idx_q  <= '0;
      inv_q  <= 1'b0;
      en_q   <= 1'b0;
      nib_q  <= '0;
      done_q <= 1'b0;
      runt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      inv_q  <= inv_d;
      en_q   <= en_d;
      nib_q  <= nib_d;
      done_q <= done_d;
      runt_q <= runt_d;
    end
  end

  assign tx_en      = en_q;
  assign tx_nib     = nib_q;
  assign abort_done = done_q;
  assign abort_runt = runt_q;

  // R4: a runt ending leaves the line silent
  a_r4_runt_silent: assert property (@(posedge clk) disable iff (rst)
    (abort_done && abort_runt) |-> !tx_en);

  // R7: the poisoned ending coincides with a line nibble
  a_r7_done_on_nibble: assert property (@(posedge clk) disable iff (rst)
    (abort_done && !abort_runt) |-> tx_en);

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    abort_done |=> !abort_done);

  // R9: the check sequence is never interrupted
  a_r9_fcs_unbroken: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FCS) |=> tx_en);

  // R8: an abort outside a frame produces no completion
  a_r8_idle_abort: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PASS && abort_req && !any_sent) |=> !abort_done);

  // R5: a long abort on a byte boundary keeps the line busy
  a_r5_boundary_keeps_line: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PASS && abort_req && long_enough && !odd_phase) |=> (tx_en && st_q == ST_FCS));

endmodule

// File: tb/sim_tx_abort_term.sv
`timescale 1ns/1ps
module sim_tx_abort_term;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_nib = 4'h0;
  logic       in_last = 1'b0;
  logic       abort_req = 1'b0;
  logic       tx_en;
  logic [3:0] tx_nib;
  logic       abort_done;
  logic       abort_runt;

  always #2.5 clk = ~clk;

  tx_abort_term u0 (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_nib     (in_nib),
    .in_last    (in_last),
    .abort_req  (abort_req),
    .tx_en      (tx_en),
    .tx_nib     (tx_nib),
    .abort_done (abort_done),
    .abort_runt (abort_runt)
  );

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 0;

  logic [7:0] dat  [0:255];
  logic [3:0] cap  [0:1023];
  logic [3:0] expn [0:1023];
  int   cap_n, exp_n, done_cnt;
  logic last_runt;
  bit   mon_on = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_en) begin
        if (cap_n < 1024) cap[cap_n] = tx_nib;
        cap_n++;
      end
      if (abort_done) begin
        done_cnt++;
        last_runt = abort_runt;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [3:0] dnib(int n);
    return n[0] ? dat[n >> 1][7:4] : dat[n >> 1][3:0];
  endfunction

  // bitwise reference CRC, LSB of each byte first, no final complement
  function automatic logic [31:0] ref_crc(int nb);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < nb; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ dat[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  function automatic void push_word(logic [31:0] w);
    for (int i = 0; i < 8; i++) begin
      expn[exp_n] = w[4*i +: 4];
      exp_n++;
    end
  endfunction

  // k < 0: no abort; k == 0: abort on the very first nibble (must be ignored)
  task automatic run_frame(input int nbytes, input int k, input bit gap,
                           input bit junk, input string tag);
    int nibs = 2 * nbytes;
    int sent;
    int mism = -1;
    bit exp_done;
    bit exp_runt = 0;
    exp_n = 0; cap_n = 0; done_cnt = 0; last_runt = 1'b0;
    if (k <= 0) begin
      for (int n = 0; n < nibs; n++) begin expn[exp_n] = dnib(n); exp_n++; end
      push_word(~ref_crc(nbytes));
      exp_done = 0;
    end else if (k < 128) begin
      for (int n = 0; n < k; n++) begin expn[exp_n] = dnib(n); exp_n++; end
      exp_done = 1; exp_runt = 1;
    end else begin
      sent = k + (k % 2);
      for (int n = 0; n < sent; n++) begin expn[exp_n] = dnib(n); exp_n++; end
      push_word(ref_crc(sent / 2));
      exp_done = 1; exp_runt = 0;
    end
    mon_on = 1;
    if (k <= 0) begin
      for (int n = 0; n < nibs; n++) begin
        @(negedge clk);
        in_valid = 1; in_nib = dnib(n); in_last = (n == nibs - 1);
        abort_req = (k == 0 && n == 0);
      end
      if (junk) begin
        for (int j = 0; j < 8; j++) begin
          @(negedge clk);
          in_valid = 1; in_nib = 4'($urandom); in_last = 1'($urandom);
          abort_req = (j == 3);
        end
      end
    end else begin
      for (int n = 0; n < k; n++) begin
        @(negedge clk);
        in_valid = 1; in_nib = dnib(n); in_last = 0; abort_req = 0;
      end
      @(negedge clk);
      abort_req = 1; in_last = 0;
      if (k % 2 == 1 && gap) in_valid = 0;
      else begin in_valid = 1; in_nib = dnib(k); end
      if (k % 2 == 1 && gap && k >= 128) begin
        @(negedge clk);
        abort_req = 0; in_valid = 1; in_nib = dnib(k);
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; abort_req = 0; in_nib = 0;
    repeat (14) @(negedge clk);
    mon_on = 0;
    chk(cap_n == exp_n, tag, "line nibble count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (mism < 0 && cap[i] !== expn[i]) mism = i;
    if (mism < 0) chk(1, tag, "line nibble", 0, 0);
    else chk(0, tag, $sformatf("line nibble %0d", mism), cap[mism], expn[mism]);
    chk(done_cnt == int'(exp_done), "R7", "completion pulses", done_cnt, exp_done);
    if (exp_done) chk(last_runt == exp_runt, tag, "runt flag", last_runt, exp_runt);
  endtask

  task automatic fill_rand(input int nbytes);
    for (int i = 0; i < nbytes; i++) dat[i] = 8'($urandom);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] fcs_word;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(!tx_en && !abort_done && !abort_runt, "R1", "outputs in reset", {tx_en, abort_done, abort_runt}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(!tx_en && !abort_done && !abort_runt, "R1", "outputs after reset", {tx_en, abort_done, abort_runt}, 0);

    // R3: known check value
    for (int i = 0; i < 9; i++) dat[i] = 8'h31 + 8'(i);
    run_frame(9, -1, 0, 0, "R3");
    fcs_word = '0;
    for (int i = 0; i < 8; i++) fcs_word[4*i +: 4] = cap[18 + i];
    chk(fcs_word == 32'hCBF43926, "R3", "FCS of 123456789", fcs_word, 32'hCBF43926);

    // R2: plain pass-through
    fill_rand(20); run_frame(20, -1, 0, 0, "R2");

    // R8: abort while idle, then abort on first nibble
    mon_on = 1; cap_n = 0; done_cnt = 0;
    @(negedge clk); abort_req = 1;
    @(negedge clk); abort_req = 0;
    repeat (4) @(negedge clk);
    mon_on = 0;
    chk(cap_n == 0 && done_cnt == 0, "R8", "idle abort activity", cap_n + done_cnt, 0);
    fill_rand(64); run_frame(64, 0, 0, 0, "R8");

    // R9: junk and abort during the FCS
    fill_rand(64); run_frame(64, -1, 0, 1, "R9");

    // R4 runt paths
    fill_rand(64); run_frame(64, 1, 0, 0, "R4");
    fill_rand(64); run_frame(64, 40, 0, 0, "R4");

    // R10 threshold edge
    fill_rand(70); run_frame(70, 127, 0, 0, "R10");
    fill_rand(70); run_frame(70, 128, 0, 0, "R10");

    // R5 boundary, R6 mid-byte with and without a stall
    fill_rand(80); run_frame(80, 150, 0, 0, "R5");
    fill_rand(80); run_frame(80, 129, 0, 0, "R6");
    fill_rand(80); run_frame(80, 133, 1, 0, "R6");

    // R11: back-to-back random frames without reset
    for (int f = 0; f < 24; f++) begin
      int nb = 65 + int'($urandom % 40);
      int mode = int'($urandom % 3);
      int k;
      bit gap = 1'($urandom);
      fill_rand(nb);
      if (mode == 0)      k = -1;
      else if (mode == 1) k = 1 + int'($urandom % 127);
      else                k = 128 + int'($urandom % (2 * nb - 128));
      run_frame(nb, k, gap, 1'(mode == 0 && gap), "R11");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule